// File: doc/BRIEF.md
# Paper-Tape Binary Record Loader

This block sits between a paper-tape reader and a memory write port. It takes the punched tape one byte at a time over a valid/ready handshake and turns the records on it into word writes. Each record opens with a nonzero word count. One pad byte follows and is thrown away. After it come a 16-bit origin word, the data words, and a 16-bit checksum word. Every word arrives as two bytes with the high byte first. Data word k of a record goes to address origin+k. The loader sums the origin and the data words and compares the total with the checksum word that closes the record.

The controller is a single state machine. `ST_LEADER` skips any number of leading zero bytes. A nonzero byte there is the count and moves the machine to `ST_PAD`. From there the chain runs `ST_ORG_HI` → `ST_ORG_LO` → `ST_DAT_HI` → `ST_DAT_LO` → `ST_WRITE`. `ST_WRITE` holds the write until memory accepts it. It then returns to `ST_DAT_HI`, or after the last word moves to `ST_SUM_HI` → `ST_SUM_LO`. A matching checksum leads to `ST_GAP`. In `ST_GAP` a nonzero byte starts the next record in `ST_PAD`, and a run of zero bytes ends the load in `ST_DONE`. A checksum mismatch leads to `ST_BAD_SUM`. The end of input inside a record leads to `ST_BAD_FMT`. The end of input in `ST_LEADER` or `ST_GAP` leads to `ST_DONE`. `ST_DONE` lasts one cycle and then passes to `ST_HALT`. `ST_HALT`, `ST_BAD_FMT` and `ST_BAD_SUM` are left only by reset.

End of input is signalled by `tape_end` high while `in_valid` is low.

Top module: `tape_ldr`

## Requirements
- R1: Any number of zero bytes before the first record is consumed without writes or status change.
- R2: Each word is built from two consecutive accepted bytes, the first one forming bits 15:8.
- R3: A record is a nonzero count byte, one pad byte whose value is ignored, the origin word, exactly count data words, then the checksum word; each data word produces exactly one write.
- R4: Data word k of a record is written to address (origin+k) modulo 2^ADDR_W, using the low ADDR_W bits of the origin.
- R5: The checksum is the 16-bit sum of the origin and all data words, with the count excluded. On a mismatch `sum_err` rises and holds until reset, and no further input is accepted.
- R6: After a good record, a nonzero byte starts the next record. Fewer than GAP_ZEROS (default 11) consecutive zeros do not end the load. The GAP_ZEROS-th consecutive zero ends it with a done pulse.
- R7: End of input (`tape_end` high, `in_valid` low) in the leader or after a complete record ends the load with a done pulse.
- R8: End of input after a count byte and before the checksum word has been fully read raises `fmt_err`, which holds until reset.
- R9: While a write is pending, `mem_we` stays high with `mem_addr` and `mem_wdata` stable until `mem_ready`, and `in_ready` is low.
- R10: `done` is high for exactly one cycle. After `done`, `fmt_err` or `sum_err`, `in_ready` and `mem_we` stay low until reset.
- R11: After reset, `in_ready` is high and `mem_we`, `done`, `fmt_err` and `sum_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Tape byte present |
| in_byte | input | 8 | Tape byte |
| tape_end | input | 1 | No more input (read while `in_valid` is low) |
| in_ready | output | 1 | Loader takes the byte this cycle |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write request, held until accepted |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| done | output | 1 | One-cycle pulse on a successful finish |
| fmt_err | output | 1 | Tape ended inside a record, sticky |
| sum_err | output | 1 | Checksum mismatch, sticky |

## Verification
The assertions assume that `mem_ready` may take any value in any cycle. They also assume that `tape_end` matters only while `in_valid` is low, and that no input carries X after reset. The bench keeps within these rules. It raises `tape_end` only after it has dropped `in_valid`. It drives `mem_ready` always high, high one cycle in three, or held low. It changes every input on the falling edge so that values are settled at the rising edge.

// File: rtl/tape_ldr_pkg.sv
package tape_ldr_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        ST_LEADER, ST_PAD, ST_ORG_HI, ST_ORG_LO,
        ST_DAT_HI, ST_DAT_LO, ST_WRITE, ST_SUM_HI,
        ST_SUM_LO, ST_GAP, ST_DONE, ST_HALT,
        ST_BAD_FMT, ST_BAD_SUM
    } ldr_state_e;

    typedef struct packed {
        logic ld_cnt;   // capture word count
        logic ld_hi;    // capture high byte
        logic ld_org;   // capture origin, seed sum
        logic ld_dat;   // capture data word, add to sum
        logic wr_ack;   // write accepted: step address, count down
    } dp_ctl_t;
endpackage

// File: rtl/tape_ldr_zrun.sv
module tape_ldr_zrun #(
    parameter int RUN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // the zero being offered now would be the RUN-th in a row
    assign last = (cnt_q == CW'(RUN - 1));
endmodule

// File: rtl/tape_ldr_dpath.sv
module tape_ldr_dpath
    import tape_ldr_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dp_ctl_t           ctl,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] wdata,
    output logic              last_word,
    output logic              sum_match
);
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] left_q;
    logic [AW-1:0]     addr_q;
    logic [WORD_W-1:0] sum_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] word_in;

    assign word_in = {hi_q, in_byte};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            left_q  <= '0;
            addr_q  <= '0;
            sum_q   <= '0;
            wdata_q <= '0;
        end else begin
            if (ctl.ld_cnt) left_q <= in_byte;
            if (ctl.ld_hi)  hi_q   <= in_byte;
            if (ctl.ld_org) begin
                addr_q <= word_in[AW-1:0];
                sum_q  <= word_in;
            end
            if (ctl.ld_dat) begin
                wdata_q <= word_in;
                sum_q   <= sum_q + word_in;
            end
            if (ctl.wr_ack) begin
                addr_q <= addr_q + AW'(1);
                left_q <= left_q - BYTE_W'(1);
            end
        end
    end

    assign addr      = addr_q;
    assign wdata     = wdata_q;
    assign last_word = (left_q == BYTE_W'(1));
    assign sum_match = (word_in == sum_q);
endmodule

// File: rtl/tape_ldr.sv
module tape_ldr
    import tape_ldr_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int GAP_ZEROS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              tape_end,
    output logic              in_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              mem_we,
    input  logic              mem_ready,
    output logic              done,
    output logic              fmt_err,
    output logic              sum_err
);
    ldr_state_e state_q, state_d;
    dp_ctl_t    ctl;
    logic       z_clr, z_step, z_last;
    logic       last_word, sum_match;
    logic       take, eoi, is_zero;

    assign take    = in_valid && in_ready;
    assign eoi     = !in_valid && tape_end;
    assign is_zero = (in_byte == '0);

    tape_ldr_dpath #(.AW(ADDR_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .in_byte   (in_byte),
        .addr      (mem_addr),
        .wdata     (mem_wdata),
        .last_word (last_word),
        .sum_match (sum_match)
    );

    tape_ldr_zrun #(.RUN(GAP_ZEROS)) u_zrun (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (z_clr),
        .step  (z_step),
        .last  (z_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LEADER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        z_clr   = 1'b0;
        z_step  = 1'b0;
        unique case (state_q)
            ST_LEADER: begin
                if (take && !is_zero) begin
                    ctl.ld_cnt = 1'b1;
                    state_d    = ST_PAD;
                end else if (eoi) begin
                    state_d = ST_DONE;
                end
            end
            ST_PAD: begin
                if (take)     state_d = ST_ORG_HI;
                else if (eoi) state_d = ST_BAD_FMT;
            end
            ST_ORG_HI: begin
                if (take) begin
                    ctl.ld_hi = 1'b1;
                    state_d   = ST_ORG_LO;
                end else if (eoi) begin
                    state_d = ST_BAD_FMT;
                end
            end
            ST_ORG_LO: begin
                if (take) begin
                    ctl.ld_org = 1'b1;
                    state_d    = ST_DAT_HI;
                end else if (eoi) begin
                    state_d = ST_BAD_FMT;
                end
            end
            ST_DAT_HI: begin
                if (take) begin
                    ctl.ld_hi = 1'b1;
                    state_d   = ST_DAT_LO;
                end else if (eoi) begin
                    state_d = ST_BAD_FMT;
                end
            end
            ST_DAT_LO: begin
                if (take) begin
                    ctl.ld_dat = 1'b1;
                    state_d    = ST_WRITE;
                end else if (eoi) begin
                    state_d = ST_BAD_FMT;
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    ctl.wr_ack = 1'b1;
                    state_d    = last_word ? ST_SUM_HI : ST_DAT_HI;
                end
            end
            ST_SUM_HI: begin
                if (take) begin
                    ctl.ld_hi = 1'b1;
                    state_d   = ST_SUM_LO;
                end else if (eoi) begin
                    state_d = ST_BAD_FMT;
                end
            end
            ST_SUM_LO: begin
                if (take) begin
                    z_clr   = 1'b1;
                    state_d = sum_match ? ST_GAP : ST_BAD_SUM;
                end else if (eoi) begin
                    state_d = ST_BAD_FMT;
                end
            end
            ST_GAP: begin
                if (take && !is_zero) begin
                    ctl.ld_cnt = 1'b1;
                    z_clr      = 1'b1;
                    state_d    = ST_PAD;
                end else if (take) begin
                    if (z_last) state_d = ST_DONE;
                    else        z_step  = 1'b1;
                end else if (eoi) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:    state_d = ST_HALT;
            ST_HALT:    state_d = ST_HALT;
            ST_BAD_FMT: state_d = ST_BAD_FMT;
            ST_BAD_SUM: state_d = ST_BAD_SUM;
            default:    state_d = ST_LEADER;
        endcase
    end

    always_comb begin
        in_ready = 1'b0;
        mem_we   = 1'b0;
        done     = 1'b0;
        fmt_err  = 1'b0;
        sum_err  = 1'b0;
        unique case (state_q)
            ST_LEADER, ST_PAD, ST_ORG_HI, ST_ORG_LO, ST_DAT_HI,
            ST_DAT_LO, ST_SUM_HI, ST_SUM_LO, ST_GAP: in_ready = 1'b1;
            ST_WRITE:   mem_we  = 1'b1;
            ST_DONE:    done    = 1'b1;
            ST_BAD_FMT: fmt_err = 1'b1;
            ST_BAD_SUM: sum_err = 1'b1;
            ST_HALT:    in_ready = 1'b0;
            default:    in_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/tape_ldr_chk.sv
module tape_ldr_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              mem_we,
    input logic              mem_ready,
    input logic              done,
    input logic              fmt_err,
    input logic              sum_err
);
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fmt_err, sum_err})); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fmt_err || sum_err) |=> (!in_ready && !mem_we)); // R10

    AST_FMT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err); // R8

    AST_SUM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sum_err |=> sum_err); // R5

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata))); // R9

    AST_NO_READY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !in_ready); // R9

    AST_ONE_WRITE_PER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready) |=> !mem_we); // R3
endmodule

bind tape_ldr tape_ldr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .done      (done),
    .fmt_err   (fmt_err),
    .sum_err   (sum_err)
);

// File: tb/tape_ldr_tb.sv
module tape_ldr_tb;
    localparam int AW = 15;

    // tape: leader, record A (2 words @0x0100), short gap,
    // record B (2 words @ origin 0xFFFF -> address wraps), 11-zero trailer
    localparam logic [7:0] TAPE [37] = '{
        8'h00, 8'h00, 8'h00,
        8'h02, 8'hA5, 8'h01, 8'h00, 8'h12, 8'h34, 8'hAB, 8'hCD, 8'hBF, 8'h01,
        8'h00, 8'h00, 8'h00,
        8'h02, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00
    };
    localparam logic [14:0] EXP_A [4] = '{15'h0100, 15'h0101, 15'h7FFF, 15'h0000};
    localparam logic [15:0] EXP_D [4] = '{16'h1234, 16'hABCD, 16'h0001, 16'hFFFF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic tape_end = 1'b0;
    logic mem_ready = 1'b1;
    logic in_ready, mem_we, done, fmt_err, sum_err;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;

    int checks = 0;
    int fails = 0;
    int rdy_mode = 0;
    int cyc = 0;
    int wr_n;
    int done_n;
    logic [AW-1:0] wr_a [16];
    logic [15:0]   wr_d [16];

    always #10 clk = ~clk;

    tape_ldr #(.ADDR_W(AW), .GAP_ZEROS(11)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .tape_end(tape_end), .in_ready(in_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_ready(mem_ready),
        .done(done), .fmt_err(fmt_err), .sum_err(sum_err)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rdy_mode == 0)      mem_ready = 1'b1;
        else if (rdy_mode == 1) mem_ready = (cyc % 3 == 0);
        else                    mem_ready = 1'b0;
    end

    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (!rst_n) begin
                wr_n = 0;
                done_n = 0;
            end else begin
                if (mem_we && mem_ready && wr_n < 16) begin
                    wr_a[wr_n] = mem_addr;
                    wr_d[wr_n] = mem_wdata;
                    wr_n = wr_n + 1;
                end
                if (done) done_n = done_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        tape_end = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte = b;
        #5;
        while (!in_ready) begin
            @(negedge clk);
            #5;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
        #5;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // reset state
        do_reset();
        #5;
        chk(in_ready == 1'b1, "R11", "in_ready", 32'(in_ready), 1);
        chk(mem_we == 1'b0, "R11", "mem_we", 32'(mem_we), 0);
        chk({done, fmt_err, sum_err} == 3'b000, "R11", "status", 32'({done, fmt_err, sum_err}), 0);

        // table walk with a stalling memory
        rdy_mode = 1;
        foreach (TAPE[i]) send(TAPE[i]);
        idle(4);
        chk(wr_n == 4, "R3", "write count", 32'(wr_n), 4);
        for (int k = 0; k < 4; k++) begin
            chk(wr_a[k] == EXP_A[k], "R4", "write address", 32'(wr_a[k]), 32'(EXP_A[k]));
            chk(wr_d[k] == EXP_D[k], "R2", "write data", 32'(wr_d[k]), 32'(EXP_D[k]));
        end
        chk(done_n == 1, "R6", "done pulses after trailer", 32'(done_n), 1);
        chk({fmt_err, sum_err} == 2'b00, "R5", "no error on good tape", 32'({fmt_err, sum_err}), 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte = 8'h05;
        repeat (3) @(negedge clk);
        #5;
        chk(in_ready == 1'b0, "R10", "in_ready after done", 32'(in_ready), 0);
        chk(wr_n == 4, "R10", "no write after done", 32'(wr_n), 4);

        // ten zeros do not end; nonzero starts next record; end after record
        do_reset();
        rdy_mode = 0;
        send(8'h01); send(8'h33); send(8'h00); send(8'h10); send(8'h55); send(8'h55);
        send(8'h55); send(8'h65);
        for (int k = 0; k < 10; k++) send(8'h00);
        send(8'h01); send(8'h00); send(8'h00); send(8'h20); send(8'h00); send(8'h01);
        send(8'h00); send(8'h21);
        idle(3);
        chk(done_n == 0, "R6", "ten zeros do not finish", 32'(done_n), 0);
        chk(wr_n == 2, "R6", "second record written", 32'(wr_n), 2);
        chk(wr_a[1] == 15'h0020, "R6", "second origin", 32'(wr_a[1]), 32'h20);
        chk(wr_d[0] == 16'h5555, "R3", "pad byte ignored", 32'(wr_d[0]), 32'h5555);
        tape_end = 1'b1;
        idle(3);
        chk(done_n == 1, "R7", "end after record", 32'(done_n), 1);
        chk(fmt_err == 1'b0, "R7", "no fmt_err at gap end", 32'(fmt_err), 0);

        // checksum mismatch (would match only if count were summed)
        do_reset();
        send(8'h01); send(8'h00); send(8'h00); send(8'h00); send(8'h00); send(8'h01);
        send(8'h00); send(8'h02);
        idle(3);
        chk(sum_err == 1'b1, "R5", "sum_err raised", 32'(sum_err), 1);
        chk(wr_n == 1, "R5", "issued write kept", 32'(wr_n), 1);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte = 8'h00;
        repeat (5) @(negedge clk);
        #5;
        chk(sum_err == 1'b1 && in_ready == 1'b0, "R5", "sum_err held, input stopped",
            32'({sum_err, in_ready}), 32'b10);

        // end of input inside record
        do_reset();
        send(8'h01); send(8'h00); send(8'h00);
        @(negedge clk);
        in_valid = 1'b0;
        tape_end = 1'b1;
        repeat (3) @(negedge clk);
        #5;
        chk(fmt_err == 1'b1, "R8", "fmt_err on early end", 32'(fmt_err), 1);
        chk(done_n == 0, "R8", "no done on early end", 32'(done_n), 0);

        // long leader, then end
        do_reset();
        for (int k = 0; k < 40; k++) send(8'h00);
        idle(2);
        chk(wr_n == 0 && done_n == 0 && in_ready == 1'b1, "R1", "leader skipped",
            32'({wr_n[3:0], done_n[3:0], in_ready}), 32'h001);
        tape_end = 1'b1;
        idle(3);
        chk(done_n == 1 && wr_n == 0, "R7", "end in leader", 32'(done_n), 1);

        // write stall
        do_reset();
        rdy_mode = 2;
        send(8'h01); send(8'h00); send(8'h12); send(8'h34); send(8'hBE); send(8'hEF);
        @(negedge clk);
        in_byte = 8'hD1;
        repeat (3) @(negedge clk);
        #5;
        chk(mem_we == 1'b1 && in_ready == 1'b0, "R9", "write pending blocks input",
            32'({mem_we, in_ready}), 32'b10);
        chk(mem_addr == 15'h1234 && mem_wdata == 16'hBEEF, "R9", "pending write held",
            32'({1'b0, mem_addr, mem_wdata}), 32'h1234BEEF);
        chk(wr_n == 0, "R9", "no write before ready", 32'(wr_n), 0);
        rdy_mode = 0;
        send(8'hD1); send(8'h23);
        idle(3);
        chk(wr_n == 1 && sum_err == 1'b0 && fmt_err == 1'b0, "R9", "write completes",
            32'(wr_n), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule